// File: doc/BRIEF.md
# Barrel Shift Unit with Carry-Out

This block is the shift stage of a small processor datapath. It takes a 32-bit operand, an unsigned 8-bit shift count and a 2-bit shift kind. It returns the shifted value, the bit that was shifted out last, and a strobe that tells the flag logic whether the carry flag should take that bit. The kinds are logical left, logical right, arithmetic right and rotate right.

Counts of 32 or more do not wrap for the three plain shifts. Each of these kinds saturates to a fixed result and carry. Rotate uses the count modulo the width.

A zero count passes the operand through unchanged and never requests a carry update. The unit is purely combinational. Instruction decode, the register file and the flag storage sit outside it.

Top module: `shift_unit`

## Requirements
- R1: When `amount_i` is 0, `result_o` equals `operand_i` for every kind, `carry_o` is 0 and `carry_upd_o` is 0.
- R2: `carry_upd_o` is 1 exactly when `set_flags_i` is 1 and `amount_i` is non-zero, for every kind.
- R3: Kind encoding on `kind_i`: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right.
- R4: Logical left by n (1–31) gives `operand_i << n` (low n bits zero) with carry equal to operand bit 32-n.
- R5: Logical left by exactly 32 gives 0 with carry equal to operand bit 0. By 33–255 it gives 0 with carry 0.
- R6: Logical right by n (1–31) gives `operand_i >> n` (top n bits zero) with carry equal to operand bit n-1.
- R7: Logical right by exactly 32 gives 0 with carry equal to operand bit 31. By 33–255 it gives 0 with carry 0.
- R8: Arithmetic right by n (1–31) fills the top n bits with operand bit 31, moves bits [31:n] down to [31-n:0], and gives carry equal to operand bit n-1.
- R9: Arithmetic right by 32–255 gives every result bit and the carry equal to operand bit 31.
- R10: Rotate right by a non-zero n gives the operand rotated right by n mod 32, with carry equal to result bit 31. This holds when n is a non-zero multiple of 32: the result is then unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Value to be shifted |
| amount_i | input | 8 | Unsigned shift count, 0–255 |
| kind_i | input | 2 | Shift kind select |
| set_flags_i | input | 1 | Request that the carry flag be updated |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Last bit shifted out |
| carry_upd_o | output | 1 | Carry flag write enable |

## Verification
Several rules are checked by embedded assertions whenever the inputs change:
- zero-count pass-through and update suppression;
- the update-enable rule;
- the link between rotate carry and result bit 31;
- the saturated arithmetic-right pattern;
- the zero result and zero carry of logical left beyond 32.

The exact bit movement for each count from 1 to 31 can only be shown by the bench's sweeps against an independent bitwise model. The same holds for the boundary carries at exactly 32 and the modulo behaviour of rotate at 32, 64 and 255.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shift_right_sat.sv
// Right shift with count already clamped to WIDTH+1; carry is the last bit out.
module shift_right_sat #(
  parameter int WIDTH = 32,
  parameter int SAT_W = 6
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [SAT_W-1:0] count_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  localparam int EXT_W = 2 * WIDTH + 2;
  localparam int IDX_W = $clog2(EXT_W);

  logic            fill;
  logic [EXT_W-1:0] ext;

  assign fill = arith_i & operand_i[WIDTH-1];
  // bit 0 is the zero-count carry slot; upper half is the fill pattern
  assign ext  = {{(WIDTH + 1){fill}}, operand_i, 1'b0};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [IDX_W-1:0] src;
    assign src         = IDX_W'(i + 1) + IDX_W'(count_i);
    assign result_o[i] = ext[src];
  end

  assign carry_o = ext[IDX_W'(count_i)];
endmodule

// File: rtl/shift_left_sat.sv
// Left shift with count already clamped to WIDTH+1; carry is the last bit out.
module shift_left_sat #(
  parameter int WIDTH = 32,
  parameter int SAT_W = 6
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [SAT_W-1:0] count_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  localparam int EXT_W = 2 * WIDTH + 2;
  localparam int IDX_W = $clog2(EXT_W);

  logic [EXT_W-1:0] ext;

  // top bit is the zero-count carry slot; low WIDTH+1 bits are shifted-in zeros
  assign ext = {1'b0, operand_i, {(WIDTH + 1){1'b0}}};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [IDX_W-1:0] src;
    assign src         = IDX_W'(i + WIDTH + 1) - IDX_W'(count_i);
    assign result_o[i] = ext[src];
  end

  assign carry_o = ext[IDX_W'(2 * WIDTH + 1) - IDX_W'(count_i)];
endmodule

// File: rtl/shift_rotate.sv
module shift_rotate #(
  parameter int WIDTH = 32,
  parameter int ROT_W = 5
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [ROT_W-1:0] count_i,
  output logic [WIDTH-1:0] result_o
);
  localparam int DBL_W = 2 * WIDTH - 1;
  localparam int IDX_W = $clog2(DBL_W);

  logic [DBL_W-1:0] dbl;

  assign dbl = {operand_i[WIDTH-2:0], operand_i};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [IDX_W-1:0] src;
    assign src         = IDX_W'(i) + IDX_W'(count_i);
    assign result_o[i] = dbl[src];
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_unit_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic [1:0]       kind_i,
  input  logic             set_flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             carry_upd_o
);
  localparam int SAT_W = $clog2(WIDTH + 2);
  localparam int ROT_W = $clog2(WIDTH);

  shift_kind_e      kind;
  logic             amt_nz;
  logic [SAT_W-1:0] count_sat;
  logic [WIDTH-1:0] rsh_res, lsh_res, rot_res;
  logic             rsh_c, lsh_c;

  assign kind      = shift_kind_e'(kind_i);
  assign amt_nz    = |amount_i;
  // every count above WIDTH behaves like WIDTH+1
  assign count_sat = (amount_i > AMT_W'(WIDTH)) ? SAT_W'(WIDTH + 1)
                                                : amount_i[SAT_W-1:0];

  shift_right_sat #(.WIDTH(WIDTH), .SAT_W(SAT_W)) u_rsh (
    .operand_i (operand_i),
    .count_i   (count_sat),
    .arith_i   (kind == SK_ASR),
    .result_o  (rsh_res),
    .carry_o   (rsh_c)
  );

  shift_left_sat #(.WIDTH(WIDTH), .SAT_W(SAT_W)) u_lsh (
    .operand_i (operand_i),
    .count_i   (count_sat),
    .result_o  (lsh_res),
    .carry_o   (lsh_c)
  );

  shift_rotate #(.WIDTH(WIDTH), .ROT_W(ROT_W)) u_rot (
    .operand_i (operand_i),
    .count_i   (amount_i[ROT_W-1:0]),
    .result_o  (rot_res)
  );

  always_comb begin
    unique case (kind)
      SK_LSL: begin
        result_o = lsh_res;
        carry_o  = lsh_c;
      end
      SK_LSR, SK_ASR: begin
        result_o = rsh_res;
        carry_o  = rsh_c;
      end
      default: begin
        result_o = rot_res;
        carry_o  = amt_nz & rot_res[WIDTH-1];
      end
    endcase
  end

  assign carry_upd_o = set_flags_i & amt_nz;

  always_comb begin
    if (amount_i == '0) begin
      a_r1_zero_pass : assert (result_o == operand_i && !carry_o && !carry_upd_o)
        else $error("R1 zero count not passed through");
    end
    a_r2_upd_enable : assert (carry_upd_o == (set_flags_i && amount_i != '0))
      else $error("R2 carry update enable wrong");
    if (kind_i == 2'b11 && amount_i != '0) begin
      a_r10_ror_carry : assert (carry_o == result_o[WIDTH-1])
        else $error("R10 rotate carry not result msb");
    end
    if (kind_i == 2'b10 && amount_i >= AMT_W'(WIDTH)) begin
      a_r9_asr_sat : assert (result_o == {WIDTH{operand_i[WIDTH-1]}} &&
                             carry_o == operand_i[WIDTH-1])
        else $error("R9 arithmetic saturation wrong");
    end
    if (kind_i == 2'b00 && amount_i > AMT_W'(WIDTH)) begin
      a_r5_lsl_over : assert (result_o == '0 && !carry_o)
        else $error("R5 left overshift not cleared");
    end
  end
endmodule

// File: tb/shift_unit_bench.sv
module shift_unit_bench;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic [W-1:0]  operand;
  logic [7:0]    amount;
  logic [1:0]    kind;
  logic          set_flags;
  logic [W-1:0]  result;
  logic          carry, carry_upd;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  shift_unit u_shift_unit (
    .operand_i   (operand),
    .amount_i    (amount),
    .kind_i      (kind),
    .set_flags_i (set_flags),
    .result_o    (result),
    .carry_o     (carry),
    .carry_upd_o (carry_upd)
  );

  function automatic void ref_model(input logic [1:0] ty, input logic [W-1:0] op,
                                    input int n, output logic [W-1:0] r,
                                    output logic c);
    r = op;
    c = 1'b0;
    if (n == 0) return;
    for (int i = 0; i < W; i++) begin
      case (ty)
        2'b00:   r[i] = (i - n >= 0) ? op[i-n] : 1'b0;
        2'b01:   r[i] = (i + n < W) ? op[i+n] : 1'b0;
        2'b10:   r[i] = (i + n < W) ? op[i+n] : op[W-1];
        default: r[i] = op[(i + (n % W)) % W];
      endcase
    end
    case (ty)
      2'b00:   c = (n <= W) ? op[W-n] : 1'b0;
      2'b01:   c = (n <= W) ? op[n-1] : 1'b0;
      2'b10:   c = (n <= W) ? op[n-1] : op[W-1];
      default: c = r[W-1];
    endcase
  endfunction

  function automatic string req_tag(input logic [1:0] ty, input int n);
    if (n == 0) return "R1";
    case (ty)
      2'b00:   return (n < W) ? "R4" : "R5";
      2'b01:   return (n < W) ? "R6" : "R7";
      2'b10:   return (n < W) ? "R8" : "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_one(input logic [1:0] ty, input logic [W-1:0] op,
                           input int n, input logic sf);
    logic [W-1:0] er;
    logic ec, eu;
    @(negedge clk);
    kind = ty; operand = op; amount = 8'(n); set_flags = sf;
    #1;
    ref_model(ty, op, n, er, ec);
    eu = sf && (n != 0);
    n_checks++;
    if (result !== er || carry !== ec) begin
      n_fail++;
      $display("FAIL %s (R3 kind %0b) n=%0d op=%h: got %h/%b exp %h/%b",
               req_tag(ty, n), ty, n, op, result, carry, er, ec);
    end
    n_checks++;
    if (carry_upd !== eu) begin
      n_fail++;
      $display("FAIL R2 kind %0b n=%0d sf=%b: got %b exp %b", ty, n, sf, carry_upd, eu);
    end
  endtask

  task automatic sweep_kind(input logic [1:0] ty);
    logic [W-1:0] pats [4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h1234_5678};
    int big [6] = '{48, 63, 64, 96, 128, 255};
    foreach (pats[p]) begin
      for (int n = 0; n <= 40; n++) check_one(ty, pats[p], n, 1'b1);
      foreach (big[b]) check_one(ty, pats[p], big[b], 1'b1);
    end
  endtask

  task automatic t_idle_state;
    // R1: all-zero inputs give a zero result, no carry, no update
    check_one(2'b00, '0, 0, 1'b0);
  endtask

  task automatic t_zero_count;
    // R1: pass-through for every kind, update held off even with set_flags
    for (int t = 0; t < 4; t++) check_one(2'(t), 32'hDEAD_BEEF, 0, 1'b1);
  endtask

  task automatic t_lsl; sweep_kind(2'b00); endtask // R4 R5
  task automatic t_lsr; sweep_kind(2'b01); endtask // R6 R7
  task automatic t_asr; sweep_kind(2'b10); endtask // R8 R9
  task automatic t_ror; sweep_kind(2'b11); endtask // R10

  task automatic t_exact_boundaries;
    // R5 R7 R9: count exactly 32 and 33
    check_one(2'b00, 32'h0000_0001, 32, 1'b1);
    check_one(2'b00, 32'h0000_0001, 33, 1'b1);
    check_one(2'b01, 32'h8000_0000, 32, 1'b1);
    check_one(2'b01, 32'h8000_0000, 33, 1'b1);
    check_one(2'b10, 32'h8000_0000, 255, 1'b1);
    check_one(2'b10, 32'h7FFF_FFFF, 32, 1'b1);
    // R10: non-zero multiples of 32 leave the value but carry = bit 31
    check_one(2'b11, 32'h8000_0000, 32, 1'b1);
    check_one(2'b11, 32'h7FFF_FFFF, 64, 1'b1);
  endtask

  task automatic t_flag_gating;
    // R2: no update request without set_flags
    for (int t = 0; t < 4; t++) begin
      check_one(2'(t), 32'hFFFF_FFFF, 1, 1'b0);
      check_one(2'(t), 32'hFFFF_FFFF, 200, 1'b0);
    end
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    operand = '0; amount = '0; kind = '0; set_flags = 1'b0;
    t_idle_state();
    t_zero_count();
    t_lsl();
    t_lsr();
    t_asr();
    t_ror();
    t_exact_boundaries();
    t_flag_gating();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule